// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

This block holds a set of independent countdown timers behind a single APB slave port. Every channel has a 32-bit down-counter, a load (reload) value, a run-style selector, an enable, an interrupt mask and a pending flag. Each channel drives its own interrupt line. The pending flags of all channels can also be read together from one status word.

Software programs a channel through its own 64-byte address window. It writes a load value, picks continuous or single-shot operation and sets the enable. A write of any data to the reload location copies the load value into the counter straight away.

A pending flag is cleared with a handshake that takes several cycles. After a clear is accepted, a busy flag reads 1 for a fixed number of cycles, and only then does the pending flag drop. Further clear requests are refused while the busy flag is set. Every register access completes with no wait states and never signals an error.

Top module: `apb_timer_bank`

## Requirements
- R1: After a synchronous reset (presetn low at a clock edge) every channel register reads 0, all pending and busy flags are 0, and every irq line is 0.
- R2: Channel n uses byte addresses n*0x40 .. n*0x40+0x3F. The word offsets inside a window are: 0x00 status (read-only), 0x04 mode, 0x08 load, 0x10 enable, 0x14 reload strobe, 0x18 current value (read-only), 0x20 clear/flags, 0x24 mask. Any other offset, and any address whose two low bits are not 00, reads 0 and ignores writes. A write to 0x18 has no effect. pready is always 1 and pslverr is always 0.
- R3: While a channel is enabled and its count is not 0, the count drops by one at every clock edge. At the edge where an enabled channel's count is 0 (the expiry edge), its pending flag is set.
- R4: With mode bit 0 = 0 (continuous), the expiry edge copies the load value back into the counter and counting goes on, so a load value L gives one expiry every L+1 cycles.
- R5: With mode bit 0 = 1 (single), the expiry edge leaves the count at 0 and clears the enable bit, which then reads 0.
- R6: A write to load (0x08) stores the data as the load value and also as the current count. A write to reload (0x14) copies the load value into the counter, whatever the data is (0 or 1).
- R7: Enable bit 0 starts the channel when written 1 and stops it when written 0. A stopped channel holds its count.
- R8: In the clear/flags register, bit 0 reads the pending flag and bit 1 reads the busy flag. Writing 1 to bit 0 while busy is 0 sets busy for CLR_CYC cycles (default 4); at the end of that time pending drops and busy returns to 0. Writing 0 to bit 0 has no effect.
- R9: While busy is 1, a write of 1 to bit 0 of the clear register is ignored and does not lengthen the busy time.
- R10: If an expiry edge is the same edge at which a clear completes, the pending flag stays 1.
- R11: Mask bit 0 = 1 forces the channel's irq line to 0, and mask bit 0 = 0 lets irq follow the pending flag. The mask does not change the pending flag.
- R12: The status word at offset 0x00 of any window holds the pending flag of channel n in bit n, with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | Always 1: no wait states |
| pslverr | output | 1 | Always 0: no error response |
| irq | output | NCH | One interrupt line per channel, pending and not masked |

## Verification
A counter expiry and the end of a clear handshake can fall on the same edge, and one of them must win. To provoke the collision, the bench enables a continuous channel with a known load value. It then waits for a computed cycle and writes the clear so that the last busy cycle ends on exactly the edge of the second expiry. The bench judges the result by reading the clear/flags register once the handshake is over: pending must still be 1 and busy must be 0, and the channel's irq line must still be high.

// File: rtl/apb_timer_bank.sv
module apb_timer_bank #(
  parameter int NCH     = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int CLR_CYC = 4
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic [NCH-1:0] irq
);
  localparam int WIN = 6;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BCW = $clog2(CLR_CYC + 1);

  localparam logic [3:0] O_STAT = 4'h0;
  localparam logic [3:0] O_MODE = 4'h1;
  localparam logic [3:0] O_LOAD = 4'h2;
  localparam logic [3:0] O_EN   = 4'h4;
  localparam logic [3:0] O_RLD  = 4'h5;
  localparam logic [3:0] O_VAL  = 4'h6;
  localparam logic [3:0] O_CLR  = 4'h8;
  localparam logic [3:0] O_MSK  = 4'h9;

  logic [AW-1:0]  chidx;
  logic [CHW-1:0] ch_sel;
  logic [3:0]     off;
  logic           hit;
  logic [NCH-1:0] wr_ch;
  logic [NCH-1:0] pend_v;

  logic [DW-1:0]  ld_q   [NCH];
  logic [DW-1:0]  cnt_q  [NCH];
  logic [BCW-1:0] bsy_q  [NCH];
  logic           mode_q [NCH];
  logic           en_q   [NCH];
  logic           msk_q  [NCH];
  logic           pend_q [NCH];

  assign chidx   = paddr >> WIN;
  assign ch_sel  = chidx[CHW-1:0];
  assign off     = paddr[WIN-1:2];
  assign hit     = (chidx < AW'(NCH)) && (paddr[1:0] == 2'b00);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic expire;
    logic clr_go;

    assign wr_ch[i]  = psel && penable && pwrite && hit && (ch_sel == CHW'(i));
    assign expire    = en_q[i] && (cnt_q[i] == '0);
    assign clr_go    = wr_ch[i] && (off == O_CLR) && pwdata[0] && (bsy_q[i] == '0);
    assign pend_v[i] = pend_q[i];
    assign irq[i]    = pend_q[i] && !msk_q[i];

    always_ff @(posedge pclk) begin
      if (!presetn) begin
        ld_q[i]   <= '0;
        cnt_q[i]  <= '0;
        bsy_q[i]  <= '0;
        mode_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
        msk_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr_ch[i] && off == O_LOAD) begin
          ld_q[i]  <= pwdata;
          cnt_q[i] <= pwdata;
        end else if (wr_ch[i] && off == O_RLD)
          cnt_q[i] <= ld_q[i];
        else if (expire)
          cnt_q[i] <= mode_q[i] ? '0 : ld_q[i];
        else if (en_q[i])
          cnt_q[i] <= cnt_q[i] - DW'(1);

        if (wr_ch[i] && off == O_EN)
          en_q[i] <= pwdata[0];
        else if (expire && mode_q[i])
          en_q[i] <= 1'b0;

        if (wr_ch[i] && off == O_MODE) mode_q[i] <= pwdata[0];
        if (wr_ch[i] && off == O_MSK)  msk_q[i]  <= pwdata[0];

        if (clr_go)
          bsy_q[i] <= BCW'(CLR_CYC);
        else if (bsy_q[i] != '0)
          bsy_q[i] <= bsy_q[i] - BCW'(1);

        if (expire)
          pend_q[i] <= 1'b1;
        else if (bsy_q[i] == BCW'(1))
          pend_q[i] <= 1'b0;
      end
    end

    p_count_down_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[i] && cnt_q[i] != '0 && !wr_ch[i]) |=> (cnt_q[i] == $past(cnt_q[i]) - DW'(1)));

    p_expire_pends_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[i] && cnt_q[i] == '0) |=> pend_q[i]);

    p_cont_reload_r4: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[i] && !mode_q[i] && cnt_q[i] == '0 && !wr_ch[i]) |=> (cnt_q[i] == $past(ld_q[i])));

    p_single_halt_r5: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[i] && mode_q[i] && cnt_q[i] == '0 && !wr_ch[i]) |=> (!en_q[i] && cnt_q[i] == '0));

    p_strobe_copy_r6: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_ch[i] && off == O_RLD) |=> (cnt_q[i] == $past(ld_q[i])));

    p_busy_drains_r9: assert property (@(posedge pclk) disable iff (!presetn)
      (bsy_q[i] != '0) |=> (bsy_q[i] == $past(bsy_q[i]) - BCW'(1)));
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && hit) begin
      case (off)
        O_STAT:  prdata = DW'(pend_v);
        O_MODE:  prdata = DW'(mode_q[ch_sel]);
        O_LOAD:  prdata = ld_q[ch_sel];
        O_EN:    prdata = DW'(en_q[ch_sel]);
        O_VAL:   prdata = cnt_q[ch_sel];
        O_CLR:   prdata = DW'({bsy_q[ch_sel] != '0, pend_q[ch_sel]});
        O_MSK:   prdata = DW'(msk_q[ch_sel]);
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: tb/apb_timer_bank_bench.sv
module apb_timer_bank_bench;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int CLR = 4;

  localparam logic [5:0] A_STAT = 6'h00;
  localparam logic [5:0] A_MODE = 6'h04;
  localparam logic [5:0] A_LOAD = 6'h08;
  localparam logic [5:0] A_EN   = 6'h10;
  localparam logic [5:0] A_RLD  = 6'h14;
  localparam logic [5:0] A_VAL  = 6'h18;
  localparam logic [5:0] A_CLR  = 6'h20;
  localparam logic [5:0] A_MSK  = 6'h24;

  logic clk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, pslverr;
  logic [NCH-1:0] irq;

  apb_timer_bank #(.NCH(NCH), .DW(DW), .AW(AW), .CLR_CYC(CLR)) u_apb_timer_bank (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0, last_wr = 0;
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  item_t cur;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (sbq.size() == 0) check(prdata, 32'hDEAD_BEEF, "scoreboard underrun");
      else begin
        cur = sbq.pop_front();
        check(prdata, cur.exp, cur.tag);
      end
    end
  end

  task automatic wr(int ch, logic [5:0] a, logic [31:0] d);
    paddr = AW'(ch * 64 + int'(a)); pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 last_wr = cyc; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(int ch, logic [5:0] a, logic [31:0] exp, string tag);
    sbq.push_back('{exp, tag});
    paddr = AW'(ch * 64 + int'(a)); pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e, t, w, v;
    repeat (3) @(posedge clk);
    #1 presetn = 1'b1;

    check(32'(irq), 0, "R1 irq after reset");
    check({30'd0, pready, pslverr}, 32'h2, "R2 pready high pslverr low");
    rd(0, A_LOAD, 0, "R1 load after reset");
    rd(2, A_VAL, 0, "R1 value after reset");
    rd(1, A_STAT, 0, "R1 R12 status after reset");
    rd(3, A_CLR, 0, "R1 clear flags after reset");

    wr(1, A_LOAD, 32'h1234);
    wr(3, A_LOAD, 32'hABCD);
    rd(1, A_LOAD, 32'h1234, "R2 ch1 load");
    rd(3, A_LOAD, 32'hABCD, "R2 ch3 load");
    rd(0, A_LOAD, 0, "R2 ch0 untouched");
    rd(1, A_VAL, 32'h1234, "R6 load write primes counter");
    wr(1, A_VAL, 5);
    rd(1, A_VAL, 32'h1234, "R2 value read-only");
    wr(0, 6'h0C, 32'hFFFF);
    rd(0, 6'h0C, 0, "R2 undefined offset");
    rd(2, 6'h3C, 0, "R2 undefined offset top");
    wr(0, 6'h05, 1);
    rd(0, A_MODE, 0, "R2 misaligned write ignored");

    wr(0, A_LOAD, 100);
    wr(0, A_EN, 1);
    e = last_wr;
    t = cyc + 1; rd(0, A_VAL, 32'(100 - (t - e)), "R3 countdown 1");
    t = cyc + 1; rd(0, A_VAL, 32'(100 - (t - e)), "R3 countdown 2");
    rd(0, A_EN, 1, "R7 enable readback");
    wr(0, A_EN, 0);
    v = 100 - (last_wr - e);
    rd(0, A_VAL, 32'(v), "R7 stopped value");
    repeat (5) @(posedge clk); #1;
    rd(0, A_VAL, 32'(v), "R7 holds while stopped");

    wr(0, A_RLD, 0);
    rd(0, A_VAL, 100, "R6 reload with data 0");
    wr(0, A_EN, 1);
    wr(0, A_EN, 0);
    rd(0, A_VAL, 98, "R7 ran two cycles");
    wr(0, A_RLD, 1);
    rd(0, A_VAL, 100, "R6 reload with data 1");

    wr(2, A_LOAD, 3);
    wr(2, A_EN, 1);
    e = last_wr;
    t = cyc + 1; rd(2, A_VAL, 32'(3 - ((t - e) % 4)), "R4 continuous a");
    t = cyc + 1; rd(2, A_VAL, 32'(3 - ((t - e) % 4)), "R4 continuous b");
    @(posedge clk); #1;
    t = cyc + 1; rd(2, A_VAL, 32'(3 - ((t - e) % 4)), "R4 continuous c");
    t = cyc + 1; rd(2, A_VAL, 32'(3 - ((t - e) % 4)), "R4 reloaded after expiry");
    rd(2, A_STAT, 4, "R12 status bit 2");
    check(32'(irq), 4, "R11 irq follows pending");

    wr(2, A_MSK, 1);
    check(32'(irq), 0, "R11 masked irq low");
    rd(2, A_STAT, 4, "R11 pending kept under mask");
    rd(2, A_MSK, 1, "R11 mask readback");
    wr(2, A_MSK, 0);
    check(32'(irq), 4, "R11 unmasked irq high");

    wr(2, A_EN, 0);
    rd(2, A_CLR, 1, "R8 pending visible");
    wr(2, A_CLR, 0);
    rd(2, A_CLR, 1, "R8 write 0 no effect");
    wr(2, A_CLR, 1);
    w = last_wr;
    t = cyc + 1; rd(2, A_CLR, ((t - w) < CLR) ? 3 : 0, "R8 busy early");
    t = cyc + 1; rd(2, A_CLR, ((t - w) < CLR) ? 3 : 0, "R8 busy late");
    t = cyc + 1; rd(2, A_CLR, ((t - w) < CLR) ? 3 : 0, "R8 cleared");
    rd(2, A_STAT, 0, "R12 status after clear");
    check(32'(irq), 0, "R8 irq after clear");

    wr(3, A_MODE, 1);
    wr(3, A_LOAD, 2);
    wr(3, A_EN, 1);
    repeat (6) @(posedge clk); #1;
    rd(3, A_EN, 0, "R5 enable cleared");
    rd(3, A_VAL, 0, "R5 count stays 0");
    rd(3, A_STAT, 8, "R5 R12 pending ch3");
    check(32'(irq), 8, "R5 irq ch3");

    wr(3, A_CLR, 1);
    w = last_wr;
    wr(3, A_CLR, 1);
    t = cyc + 1; rd(3, A_CLR, ((t - w) < CLR) ? 3 : 0, "R9 busy during second write");
    t = cyc + 1; rd(3, A_CLR, ((t - w) < CLR) ? 3 : 0, "R9 busy not extended");

    wr(1, A_LOAD, 7);
    wr(1, A_EN, 1);
    e = last_wr;
    while (cyc < e + 10) begin @(posedge clk); #1; end
    wr(1, A_CLR, 1);
    check(32'(last_wr), 32'(e + 12), "R10 clear timed for collision");
    while (cyc < e + 16) begin @(posedge clk); #1; end
    rd(1, A_CLR, 1, "R10 expiry wins over clear completion");
    check(32'(irq), 2, "R10 irq stays high");
    wr(1, A_EN, 0);

    repeat (2) @(posedge clk); #1;
    check(32'(sbq.size()), 0, "scoreboard drained");
    finish_run();
  end
endmodule